// File: doc/BRIEF.md
# Serial Bus Control and Signal-Detection Register

An 8-bit control and status register for a two-wire serial bus interface. Software uses three write-one-to-trigger bits. One sets the serial-output latch high to signal bus release. One pulls the latch low to signal a command. One arms a single acknowledge pulse that is timed to the serial clock. The trigger bits act once, clear themselves and always read back as zero.

The block also watches the serial clock and data lines. Both are brought into the system clock domain through a synchronizer. A rising data edge while the clock is high is a release condition, and a falling data edge while the clock is high is a command condition. Each condition sets a sticky flag. Each flag has its own set of clear events:

- the release flag is cleared by a transfer-start strobe, an address-mismatch strobe or loss of enable;
- the command flag is cleared by a transfer-start strobe, a release condition or loss of enable.

Top module: `sbus_ctl_reg`

## Requirements
- R1: After reset, `rd_data` is 00h, `so_latch` is 1 and `ack_pull` is 0.
- R2: A write changes only the bits selected by `wr_mask`. Bit 7 (bus busy enable) and bit 5 (acknowledge enable) are plain storage. Bits 6, 3 and 2 ignore writes. Bits 6, 4, 1 and 0 always read 0.
- R3: With `if_en` high, writing 1 to bit 0 sets `so_latch` to 1 on the next cycle. If bit 0 and bit 1 are written as 1 together, the release action wins and `so_latch` becomes 1.
- R4: With `if_en` high, writing 1 to bit 1 alone clears `so_latch` to 0 on the next cycle.
- R5: While `if_en` is low, writes of 1 to bits 0, 1 and 4 have no effect.
- R6: A release condition (synchronized `sda_in` rising while synchronized `scl_in` is high) sets bit 2 within four cycles and clears bit 3.
- R7: A command condition (synchronized `sda_in` falling while synchronized `scl_in` is high) sets bit 3 within four cycles.
- R8: `xfer_start` or `addr_miss` clears bit 2 on the next cycle. A clear wins over a same-cycle set.
- R9: `xfer_start` clears bit 3 on the next cycle, and `addr_miss` leaves bit 3 unchanged.
- R10: While `if_en` is low, bits 2 and 3 are held at 0 and `ack_pull` is 0.
- R11: After a write of 1 to bit 4, `ack_pull` goes high at the first synchronized falling edge of `scl_in`. It stays high until the next such falling edge and is then 0. Exactly one pulse is produced per write.
- R12: A pending acknowledge is cancelled by `xfer_start` or by `if_en` going low, so that the next falling edge of `scl_in` produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| if_en | input | 1 | Serial interface enable |
| wr_en | input | 1 | Register write strobe |
| wr_mask | input | 8 | Per-bit write select |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| xfer_start | input | 1 | Transfer-start strobe |
| addr_miss | input | 1 | Address-mismatch strobe during address reception |
| scl_in | input | 1 | Serial clock from the bus (asynchronous) |
| sda_in | input | 1 | Serial data from the bus (asynchronous) |
| so_latch | output | 1 | Serial-output latch value |
| ack_pull | output | 1 | High while the acknowledge drives data low |

## Verification
The hardest case to reach is the acknowledge window. It has to be armed by a register write, then opened and closed by two separate synchronized falling edges of the serial clock, and no bus condition may fire along the way. The bench holds data high while it moves the serial clock. It waits out the synchronizer latency before each sample. This lets it see the pulse open, persist across a rising edge, close at the following fall, and fail to reappear. Cancellation is reached by arming the pulse, then applying a transfer start or dropping enable before the clock falls.

// File: rtl/sbus_ctl_reg.sv
module sbus_ctl_reg #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       if_en,
  input  logic       wr_en,
  input  logic [7:0] wr_mask,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       xfer_start,
  input  logic       addr_miss,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       so_latch,
  output logic       ack_pull
);

  logic [SYNC-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d;
  logic busy_en, ack_en, rel_seen, cmd_seen, ack_pend;

  wire scl_s = scl_sr[SYNC-1];
  wire sda_s = sda_sr[SYNC-1];
  wire rel_det  = scl_s & sda_s & ~sda_d;
  wire cmd_det  = scl_s & ~sda_s & sda_d;
  wire scl_fall = ~scl_s & scl_d;

  wire [7:0] wr_sel = {8{wr_en}} & wr_mask;
  wire [7:0] wr_hit = wr_sel & wr_data;
  wire rel_go = wr_hit[0] & if_en;
  wire cmd_go = wr_hit[1] & if_en;
  wire ack_go = wr_hit[4] & if_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC-2:0], scl_in};
      sda_sr <= {sda_sr[SYNC-2:0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_en <= 1'b0;
      ack_en  <= 1'b0;
    end else begin
      if (wr_sel[7]) busy_en <= wr_data[7];
      if (wr_sel[5]) ack_en  <= wr_data[5];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      so_latch <= 1'b1;
    else if (rel_go) so_latch <= 1'b1;
    else if (cmd_go) so_latch <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              rel_seen <= 1'b0;
    else if (!if_en || xfer_start || addr_miss) rel_seen <= 1'b0;
    else if (rel_det)                        rel_seen <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              cmd_seen <= 1'b0;
    else if (!if_en || xfer_start || rel_det) cmd_seen <= 1'b0;
    else if (cmd_det)                        cmd_seen <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_pend <= 1'b0;
      ack_pull <= 1'b0;
    end else if (!if_en || xfer_start) begin
      ack_pend <= 1'b0;
      ack_pull <= 1'b0;
    end else begin
      if (ack_go)        ack_pend <= 1'b1;
      else if (scl_fall) ack_pend <= 1'b0;
      if (scl_fall)      ack_pull <= ack_pend;
    end

  assign rd_data = {busy_en, 1'b0, ack_en, 1'b0, cmd_seen, rel_seen, 2'b00};

endmodule

module sbus_ctl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       if_en,
  input logic       wr_en,
  input logic [7:0] wr_mask,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       xfer_start,
  input logic       so_latch,
  input logic       ack_pull
);

  assert_trig_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6] == 1'b0 && rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00);

  assert_release_sets_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mask[0] && wr_data[0] && if_en) |=> so_latch);

  assert_command_clears_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mask[1] && wr_data[1] && !(wr_mask[0] && wr_data[0]) && if_en) |=> !so_latch);

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && if_en && (wr_mask[1:0] & wr_data[1:0]) != 2'b00) |=> $stable(so_latch));

  assert_xfer_clears_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> rd_data[3:2] == 2'b00);

  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |=> (rd_data[3:2] == 2'b00 && !ack_pull));

endmodule

bind sbus_ctl_reg sbus_ctl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .if_en(if_en), .wr_en(wr_en), .wr_mask(wr_mask),
  .wr_data(wr_data), .rd_data(rd_data), .xfer_start(xfer_start),
  .so_latch(so_latch), .ack_pull(ack_pull)
);

// File: tb/sbus_ctl_reg_tb.sv
`timescale 1ns/1ps
module sbus_ctl_reg_tb;
  logic clk = 0, rst_n = 0, if_en = 0, wr_en = 0, xfer_start = 0, addr_miss = 0;
  logic scl_in = 1, sda_in = 1;
  logic [7:0] wr_mask = 0, wr_data = 0;
  logic [7:0] rd_data;
  logic so_latch, ack_pull;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sbus_ctl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .wr_en(wr_en), .wr_mask(wr_mask),
    .wr_data(wr_data), .rd_data(rd_data), .xfer_start(xfer_start),
    .addr_miss(addr_miss), .scl_in(scl_in), .sda_in(sda_in),
    .so_latch(so_latch), .ack_pull(ack_pull)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] m, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_mask = m; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_mask = 0; wr_data = 0;
  endtask

  task automatic pulse_xfer();
    @(negedge clk); xfer_start = 1;
    @(negedge clk); xfer_start = 0;
  endtask

  task automatic pulse_miss();
    @(negedge clk); addr_miss = 1;
    @(negedge clk); addr_miss = 0;
  endtask

  task automatic sda(logic v); sda_in = v; cyc(4); endtask
  task automatic scl(logic v); scl_in = v; cyc(4); endtask

  task automatic t_reset();
    rst_n = 0; cyc(3); rst_n = 1; if_en = 1; cyc(2);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 so_latch", {7'd0, so_latch}, 8'h01);
    chk("R1 ack_pull", {7'd0, ack_pull}, 8'h00);
  endtask

  task automatic t_triggers();
    wr(8'h02, 8'h02);
    chk("R4 command latch", {7'd0, so_latch}, 8'h00);
    chk("R2 trigger reads zero", rd_data, 8'h00);
    wr(8'h01, 8'h01);
    chk("R3 release latch", {7'd0, so_latch}, 8'h01);
    wr(8'h02, 8'h02);
    wr(8'h03, 8'h03);
    chk("R3 both triggers release wins", {7'd0, so_latch}, 8'h01);
  endtask

  task automatic t_bitwrite();
    wr(8'h20, 8'hFF);
    chk("R2 masked write", rd_data, 8'h20);
    chk("R2 latch untouched", {7'd0, so_latch}, 8'h01);
    scl(0);
    chk("R2 unselected ack trigger", {7'd0, ack_pull}, 8'h00);
    scl(1);
    wr(8'h80, 8'h80);
    chk("R2 busy bit", rd_data, 8'hA0);
    wr(8'h5C, 8'hFF);
    chk("R2 read-only bits", rd_data, 8'hA0);
    chk("R2 ack trigger reads zero", {7'd0, ack_pull}, 8'h00);
    wr(8'hA0, 8'h00);
    chk("R2 clear storage", rd_data, 8'h00);
  endtask

  task automatic t_detect();
    scl_in = 1; cyc(4);
    sda(0);
    chk("R7 command detect", rd_data, 8'h08);
    sda(1);
    chk("R6 release detect clears command", rd_data, 8'h04);
  endtask

  task automatic t_clears();
    sda(0);
    chk("R7 command with release", rd_data, 8'h0C);
    pulse_miss();
    chk("R8 R9 mismatch clears release only", rd_data, 8'h08);
    sda(1);
    sda(0);
    chk("R7 both flags", rd_data, 8'h0C);
    pulse_xfer();
    chk("R8 R9 transfer start clears both", rd_data, 8'h00);
    sda(1);
    chk("R6 release again", rd_data, 8'h04);
  endtask

  task automatic t_enable();
    @(negedge clk); if_en = 0; cyc(2);
    chk("R10 flags cleared", rd_data, 8'h00);
    wr(8'h02, 8'h02);
    chk("R5 disabled trigger ignored", {7'd0, so_latch}, 8'h01);
    sda(0);
    chk("R10 no detect while disabled", rd_data, 8'h00);
    @(negedge clk); if_en = 1;
    sda(1);
    chk("R6 enabled release", rd_data, 8'h04);
  endtask

  task automatic t_ack();
    wr(8'h10, 8'h10);
    chk("R11 no pull before fall", {7'd0, ack_pull}, 8'h00);
    scl(0);
    chk("R11 pull at first fall", {7'd0, ack_pull}, 8'h01);
    scl(1);
    chk("R11 pull held over rise", {7'd0, ack_pull}, 8'h01);
    scl(0);
    chk("R11 pull ends at next fall", {7'd0, ack_pull}, 8'h00);
    scl(1); scl(0);
    chk("R11 single pulse", {7'd0, ack_pull}, 8'h00);
    scl(1);
    chk("R11 flags untouched", rd_data, 8'h04);
  endtask

  task automatic t_ack_cancel();
    wr(8'h10, 8'h10);
    pulse_xfer();
    scl(0);
    chk("R12 cancelled by transfer start", {7'd0, ack_pull}, 8'h00);
    scl(1);
    wr(8'h10, 8'h10);
    @(negedge clk); if_en = 0;
    @(negedge clk); if_en = 1;
    scl(0);
    chk("R12 cancelled by disable", {7'd0, ack_pull}, 8'h00);
    scl(1);
    wr(8'h10, 8'h10);
    scl(0);
    chk("R11 pull active", {7'd0, ack_pull}, 8'h01);
    @(negedge clk); if_en = 0; cyc(2);
    chk("R10 disable stops pull", {7'd0, ack_pull}, 8'h00);
    @(negedge clk); if_en = 1;
    scl(1);
  endtask

  initial begin
    t_reset();
    t_triggers();
    t_bitwrite();
    t_detect();
    t_clears();
    t_enable();
    t_ack();
    t_ack_cancel();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule